// File: doc/BRIEF.md
# Power-Management Wake Event Controller

This block holds the power-management control and status state of a network adapter and turns wake events into a system wake. The receive path and the PHY report three kinds of event as single-cycle pulses: a magic packet was seen, a wake-up frame was seen, and the link state changed. Software, or the configuration logic, arms the block by selecting a sleep power state and setting an enable bit. While armed, any accepted event latches a power-management event status and a wake interrupt status. Either latched status pulls the active-low interrupt line low and drives the active-high LAN wake pin high.

Two configuration inputs, loaded from non-volatile memory at power-up, can suppress magic-packet events and link-change events. Wake-up frame events cannot be suppressed. Software reads and writes two registers through a simple port: the power-management control/status register and the interrupt status register. Both status bits are write-one-to-clear. The wake pins release only when both status bits are clear.

Top module: `pm_wake_ctrl`

## Requirements
- R1: After reset, both registers read 0, `intN` is 1 and `lanWake` is 0.
- R2: With `regSel`=0 the power-management register is selected. Bits 1:0 hold the power state (0 = D0, 1..3 = sleep states D1..D3) and bit 8 holds the enable; both are read/write. Bit 15 is the event status. Every other bit reads 0. With `regSel`=1 the interrupt status register is selected, and only bit 28 (wake interrupt) is ever nonzero. Read data is combinational on `regSel`.
- R3: An accepted event, meaning enable=1 and power state nonzero, sets bit 15 of the power-management register and bit 28 of the interrupt status register at the next rising clock edge.
- R4: While either status bit is 1, `intN` is 0 and `lanWake` is 1. Both pins change in the same cycle as the status bits.
- R5: Writing 1 to bit 15 (with `regSel`=0) clears the event status. Writing 1 to bit 28 (with `regSel`=1) clears the wake interrupt. Writing 0 to either bit leaves it unchanged. The pins stay asserted until both status bits are 0.
- R6: Events that arrive while the power state is D0, or while enable is 0, are ignored.
- R7: While `cfgMagicDis`=1, magic-packet events are ignored. While `cfgLinkDis`=1, link-change events are ignored. Wake-up frame events are always accepted.
- R8: Several events in one cycle produce one latched status. If an accepted event and a clearing write occur in the same cycle, the status stays set.
- R9: Whether an event is accepted depends on the register values before a write that lands in the same cycle as the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 power management, 1 interrupt status |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register |
| cfgMagicDis | input | 1 | Suppresses magic-packet events |
| cfgLinkDis | input | 1 | Suppresses link-change events |
| evMagic | input | 1 | Magic packet seen (pulse) |
| evFrame | input | 1 | Wake-up frame seen (pulse) |
| evLink | input | 1 | Link state changed (pulse) |
| intN | output | 1 | Active-low interrupt |
| lanWake | output | 1 | Active-high wake pin |

## Verification
A wrong gating state, such as an enable or power state that was latched incorrectly, shows up one edge after the next event pulse. The two status bits and both pins then take the wrong level, and a readback of the power-management register shows the bad field at once. A status bit that fails to hold, or fails to clear, shows on `intN` and `lanWake` in the cycle after the clearing write. Writing the two clears separately exposes a pin that releases early. Same-cycle collisions between an event and a write are driven on purpose, so that a wrong priority or a gate that looks at the new register values shows as a status bit that differs one cycle later.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;

  localparam int NUM_WAKE_EV = 3;
  localparam int EV_MAGIC    = 0;
  localparam int EV_FRAME    = 1;
  localparam int EV_LINK     = 2;

  typedef enum logic [1:0] {
    PS_D0 = 2'd0,
    PS_D1 = 2'd1,
    PS_D2 = 2'd2,
    PS_D3 = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic wrCtrl;   // load power state and enable
    logic setWake;  // latch both wake statuses
    logic clrPme;   // write-one-to-clear event status
    logic clrWint;  // write-one-to-clear wake interrupt
  } wakeStrobe_t;

endpackage

// File: rtl/pm_wake_seq.sv
module pm_wake_seq
  import pm_wake_pkg::*;
#(
  parameter int NUM_EV = NUM_WAKE_EV
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic              wrPmeBit,
  input  logic              wrWintBit,
  input  logic [NUM_EV-1:0] evIn,
  input  logic [NUM_EV-1:0] evDis,
  input  logic              curEn,
  input  pwrState_t         curState,
  output wakeStrobe_t       strobe
);

  logic [NUM_EV-1:0] evQual;
  logic              armed;

  // Per-event mask; a disabled source never contributes.
  for (genvar g = 0; g < NUM_EV; g++) begin : g_qual
    assign evQual[g] = evIn[g] & ~evDis[g];
  end

  // Armed only in a sleep state with the feature enabled, judged on the
  // register values before any write landing in this cycle.
  assign armed = curEn && (curState != PS_D0);

  always_comb begin
    strobe         = '0;
    strobe.setWake = armed && (|evQual);
    strobe.wrCtrl  = regWrEn && !regSel;
    strobe.clrPme  = regWrEn && !regSel && wrPmeBit;
    strobe.clrWint = regWrEn &&  regSel && wrWintBit;
  end

  // R6: no wake strobe in D0 or with the feature disabled.
  p_ignored_when_unarmed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curState == PS_D0 || !curEn) |-> !strobe.setWake);

  // R7: a lone magic event with its disable set produces nothing.
  p_magic_masked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (evIn[EV_MAGIC] && evDis[EV_MAGIC] && !evIn[EV_FRAME] && !evIn[EV_LINK])
      |-> !strobe.setWake);

endmodule

// File: rtl/pm_wake_regs.sv
module pm_wake_regs
  import pm_wake_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STATE_W  = 2,
  parameter int EN_BIT   = 8,
  parameter int PME_BIT  = 15,
  parameter int WINT_BIT = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  wakeStrobe_t       strobe,
  input  logic              regSel,
  input  logic [STATE_W-1:0] wrState,
  input  logic              wrEn,
  output logic              curEn,
  output pwrState_t         curState,
  output logic [DATA_W-1:0] regRdData,
  output logic              intN,
  output logic              lanWake
);

  pwrState_t pwrState;
  logic      pmEn;
  logic      pmeSts;
  logic      wakeInt;
  logic      pinAssert;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrState <= PS_D0;
      pmEn     <= 1'b0;
    end else if (strobe.wrCtrl) begin
      pwrState <= pwrState_t'(wrState);
      pmEn     <= wrEn;
    end
  end

  // Set has priority over a same-cycle clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pmeSts  <= 1'b0;
      wakeInt <= 1'b0;
    end else begin
      if (strobe.setWake)     pmeSts <= 1'b1;
      else if (strobe.clrPme) pmeSts <= 1'b0;
      if (strobe.setWake)      wakeInt <= 1'b1;
      else if (strobe.clrWint) wakeInt <= 1'b0;
    end
  end

  assign curEn     = pmEn;
  assign curState  = pwrState;
  assign pinAssert = pmeSts | wakeInt;
  assign intN      = ~pinAssert;
  assign lanWake   = pinAssert;

  always_comb begin
    regRdData = '0;
    if (!regSel) begin
      regRdData[STATE_W-1:0] = pwrState;
      regRdData[EN_BIT]      = pmEn;
      regRdData[PME_BIT]     = pmeSts;
    end else begin
      regRdData[WINT_BIT]    = wakeInt;
    end
  end

  // R3/R4: a wake strobe shows on the pins at the next edge.
  p_wake_drives_pins_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setWake |=> (!intN && lanWake && pmeSts && wakeInt));

  // R5: a clear without a competing set drops the status.
  p_clear_pme_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrPme && !strobe.setWake) |=> !pmeSts);

  // R5: status is sticky until cleared.
  p_pme_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pmeSts && !strobe.clrPme) |=> pmeSts);

  // R8: a set wins against a same-cycle clear.
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setWake && strobe.clrWint) |=> wakeInt);

endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pm_wake_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STATE_W  = 2,
  parameter int EN_BIT   = 8,
  parameter int PME_BIT  = 15,
  parameter int WINT_BIT = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              cfgMagicDis,
  input  logic              cfgLinkDis,
  input  logic              evMagic,
  input  logic              evFrame,
  input  logic              evLink,
  output logic              intN,
  output logic              lanWake
);

  localparam int NUM_EV = NUM_WAKE_EV;

  wakeStrobe_t       strobe;
  logic [NUM_EV-1:0] evIn;
  logic [NUM_EV-1:0] evDis;
  logic              curEn;
  pwrState_t         curState;
  logic              unusedWrBits;

  assign evIn[EV_MAGIC]  = evMagic;
  assign evIn[EV_FRAME]  = evFrame;
  assign evIn[EV_LINK]   = evLink;
  assign evDis[EV_MAGIC] = cfgMagicDis;
  assign evDis[EV_FRAME] = 1'b0;
  assign evDis[EV_LINK]  = cfgLinkDis;
  assign unusedWrBits    = ^regWrData;

  pm_wake_seq #(.NUM_EV(NUM_EV)) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .wrPmeBit  (regWrData[PME_BIT]),
    .wrWintBit (regWrData[WINT_BIT]),
    .evIn      (evIn),
    .evDis     (evDis),
    .curEn     (curEn),
    .curState  (curState),
    .strobe    (strobe)
  );

  pm_wake_regs #(
    .DATA_W  (DATA_W),
    .STATE_W (STATE_W),
    .EN_BIT  (EN_BIT),
    .PME_BIT (PME_BIT),
    .WINT_BIT(WINT_BIT)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regSel    (regSel),
    .wrState   (regWrData[STATE_W-1:0]),
    .wrEn      (regWrData[EN_BIT]),
    .curEn     (curEn),
    .curState  (curState),
    .regRdData (regRdData),
    .intN      (intN),
    .lanWake   (lanWake)
  );

endmodule

// File: tb/pm_wake_ctrl_tb.sv
`timescale 1ns/1ps
module pm_wake_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cfgMagicDis = 1'b0;
  logic        cfgLinkDis = 1'b0;
  logic        evMagic = 1'b0;
  logic        evFrame = 1'b0;
  logic        evLink = 1'b0;
  logic        intN;
  logic        lanWake;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pm_wake_ctrl u_dut (.*);

  // Vector: {expWake, state[1:0], en, magicDis, linkDis, ev{link,frame,magic}}
  localparam int NV = 12;
  localparam logic [8:0] VEC [NV] = '{
    9'b1_11_1_00_001,  // magic in D3
    9'b0_00_1_00_001,  // D0 ignored
    9'b0_01_0_00_010,  // enable off ignored
    9'b1_10_1_00_010,  // frame in D2
    9'b1_01_1_00_100,  // link in D1
    9'b0_11_1_10_001,  // magic masked
    9'b0_11_1_01_100,  // link masked
    9'b1_11_1_11_010,  // frame never masked
    9'b1_10_1_10_101,  // magic masked, link passes
    9'b1_01_1_00_111,  // all at once
    9'b0_11_1_00_000,  // no event
    9'b0_00_0_00_111   // all, unarmed
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic sel, output logic [31:0] d);
    regSel = sel;
    #1 d = regRdData;
  endtask

  task automatic pulse(input logic [2:0] ev);
    @(negedge clk);
    {evLink, evFrame, evMagic} = ev;
    @(negedge clk);
    {evLink, evFrame, evMagic} = '0;
  endtask

  task automatic checkWake(input string tag, input logic exp);
    logic [31:0] d;
    regRead(1'b0, d);
    check({tag, " pme bit15"}, {31'd0, d[15]}, {31'd0, exp});
    regRead(1'b1, d);
    check({tag, " wake int bit28"}, d, exp ? 32'h1000_0000 : 32'h0);
    check({tag, " intN"}, {31'd0, intN}, {31'd0, ~exp});
    check({tag, " lanWake"}, {31'd0, lanWake}, {31'd0, exp});
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    #12 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regRead(1'b0, d); check("R1 pm reg", d, 32'h0);
    regRead(1'b1, d); check("R1 int reg", d, 32'h0);
    check("R1 intN", {31'd0, intN}, 32'd1);
    check("R1 lanWake", {31'd0, lanWake}, 32'd0);

    // R2 field layout
    regWrite(1'b0, 32'hFFFF_FFFF);
    regRead(1'b0, d); check("R2 pm readback", d, 32'h0000_0103);
    regRead(1'b1, d); check("R2 int readback", d, 32'h0);
    regWrite(1'b0, 32'h0000_0002);
    regRead(1'b0, d); check("R2 pm readback2", d, 32'h0000_0002);

    // Vector walk: R3 R4 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      v = VEC[i];
      regWrite(1'b0, {23'd0, v[5], 6'd0, v[7:6]});
      cfgMagicDis = v[4];
      cfgLinkDis  = v[3];
      pulse(v[2:0]);
      checkWake($sformatf("R3/R6/R7 vec%0d", i), v[8]);
      cfgMagicDis = 1'b0; cfgLinkDis = 1'b0;
      regWrite(1'b0, 32'h0000_8000);
      regWrite(1'b1, 32'h1000_0000);
      checkWake($sformatf("R5 cleanup vec%0d", i), 1'b0);
    end

    // R5 separate clears; pins held until both clear
    regWrite(1'b0, 32'h0000_0103);
    pulse(3'b010);
    regWrite(1'b0, 32'h0000_8103);
    regRead(1'b0, d); check("R5 pme cleared", d, 32'h0000_0103);
    check("R5 lanWake held", {31'd0, lanWake}, 32'd1);
    check("R5 intN held", {31'd0, intN}, 32'd0);
    regWrite(1'b1, 32'hEFFF_FFFF);
    regRead(1'b1, d); check("R5 write0 keeps wint", d, 32'h1000_0000);
    regWrite(1'b1, 32'h1000_0000);
    regRead(1'b1, d); check("R5 wint cleared", d, 32'h0);
    check("R5 lanWake released", {31'd0, lanWake}, 32'd0);
    check("R5 intN released", {31'd0, intN}, 32'd1);

    // R8 event and clear in same cycle: set wins
    @(negedge clk);
    regWrEn = 1'b1; regSel = 1'b0; regWrData = 32'h0000_8103; evMagic = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; evMagic = 1'b0;
    regRead(1'b0, d); check("R8 set wins", d, 32'h0000_8103);
    regWrite(1'b0, 32'h0000_8000);
    regWrite(1'b1, 32'h1000_0000);

    // R9 write arming in same cycle as event: old values gate (ignored)
    @(negedge clk);
    regWrEn = 1'b1; regSel = 1'b0; regWrData = 32'h0000_0103; evFrame = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; evFrame = 1'b0;
    regRead(1'b0, d); check("R9 arm same cycle ignored", d, 32'h0000_0103);
    check("R9 lanWake low", {31'd0, lanWake}, 32'd0);
    // R9 write disarming in same cycle as event: old values accept
    @(negedge clk);
    regWrEn = 1'b1; regSel = 1'b0; regWrData = 32'h0000_0000; evLink = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; evLink = 1'b0;
    regRead(1'b0, d); check("R9 disarm same cycle accepted", d, 32'h0000_8000);
    check("R9 intN low", {31'd0, intN}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule